// File: doc/BRIEF.md
# Multi-mode 16-bit timer core

A 16-bit counter that advances on prescaled ticks taken from one of four tick-enable inputs. A word-wide control register chooses the tick source, the prescale ratio and one of four count modes: halted, up to a period value, free-running over the full 16-bit range, or triangular up/down between zero and the period value. The counter's wrap condition depends on the mode. When it occurs, an overflow flag is set, and this flag drives an interrupt request when the enable bit is on.

Software reaches the block through a simple synchronous register port with three registers: control, counter (read-only) and period. Reads are combinational from the current address. A write takes effect at the clock edge on which `reg_wr` is high. Writing a one to the clear bit restarts the counter, the prescaler and the count direction. There are no streaming interfaces. Every pin is a plain control or status signal.

Top module: `tmr16_core`

## Requirements
- R1: Mode code 00 (control bits 5:4) halts the counter: it keeps its value while the code is 00.
- R2: Mode code 01 counts 0,1,...,P, where P is the period register, and then returns to 0. The overflow flag (control bit 0) is set on the step from P to 0. A counter already above P also returns to 0 on its next step.
- R3: Mode code 10 counts up to 0xFFFF and then returns to 0. The overflow flag is set on the step from 0xFFFF to 0.
- R4: Mode code 11 counts up to P and then down to 0, repeating. The overflow flag is set on the step from 1 down to 0. When P is 0 the counter stays at 0.
- R5: Control bits 9:8 select which `src_tick` bit feeds the prescaler. Control bits 7:6, with codes 00/01/10/11, make the counter step once every 1/2/4/8 selected ticks. No ticks are counted in mode 00.
- R6: Writing control with bit 2 set resets the counter to 0, resets the prescaler and sets the direction to up. Bit 2 always reads 0. Counting resumes upward on the next qualifying tick.
- R7: A control write loads bit 0 into the overflow flag, so writing 0 clears it. A hardware overflow in the same cycle leaves the flag set.
- R8: `irq` is high exactly when the overflow flag and the interrupt enable (control bit 1) are both 1.
- R9: After reset, the control, counter and period registers all read 0 and `irq` is low.
- R10: Address 0 is control, address 1 is the counter, address 2 is the period and address 3 reads 0. Writes to address 1 are ignored. Control bits 3 and 15:10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Tick enables; one is selected as the prescaler input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench aims at the corner cases of each mode.

- **Up/down turnaround at P and at zero.** A design that repeated P or 0, or that missed the direction change, would give a wrong count sequence.
- **Period of 0 in up/down mode.** A naive decrement there would wrap the counter to 0xFFFF.
- **Full 16-bit wrap in free-running mode.** The flag must be set exactly on the step from 0xFFFF to 0.
- **Clear and prescaler behaviour.** A clear must reset the prescaler phase, and a tick source that never pulses must hold the counter still. A prescaler that did not reset would show a count that is out of step.
- **Overflow racing a software clear.** A flag write in the same cycle as a hardware overflow must leave the flag set. Getting this wrong drops an interrupt.

A long randomised phase compares every register against a behavioural model on every clock. It writes modes, periods, clears and flag values at random.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd2;

  // control field positions (fixed layout)
  localparam int B_FLAG    = 0;
  localparam int B_IE      = 1;
  localparam int B_CLR     = 2;
  localparam int B_MODE    = 4;
  localparam int B_DIV     = 6;
  localparam int B_SEL     = 8;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [W-1:0]     wdata,
  input  logic             ovf_set,
  output logic             flag_q,
  output logic             ie_q,
  output tmr_mode_e        mode_q,
  output logic [DIV_W-1:0] div_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             clr_pulse
);
  // clear is a strobe only: never stored, so it always reads back as 0
  assign clr_pulse = wr_ctrl & wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= MODE_HALT;
      div_q  <= '0;
      sel_q  <= '0;
    end else begin
      // hardware set has priority over a software load of 0
      flag_q <= ovf_set | (wr_ctrl ? wdata[B_FLAG] : flag_q);
      if (wr_ctrl) begin
        ie_q   <= wdata[B_IE];
        mode_q <= tmr_mode_e'(wdata[B_MODE +: 2]);
        div_q  <= wdata[B_DIV +: DIV_W];
        sel_q  <= wdata[B_SEL +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             adv
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] mask;

  // mask = ratio - 1, built as a thermometer of width div
  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(div));
  end

  // >= so that lowering the ratio mid-count cannot strand the counter
  assign adv = run & tick & ~clr & (pre_q >= mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre_q <= '0;
    end else if (run && tick) begin
      pre_q <= (pre_q >= mask) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt_q,
  output logic         ovf_set
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         up_q;
  logic [W-1:0] cnt_d;
  logic         up_d;

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    ovf_set = 1'b0;
    if (adv) begin
      unique case (mode)
        MODE_UP: begin
          if (cnt_q >= period) begin
            cnt_d   = '0;
            ovf_set = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MODE_FREE: begin
          cnt_d   = cnt_q + ONE;
          ovf_set = &cnt_q;
        end
        MODE_UPDN: begin
          if (period == '0) begin
            cnt_d = '0;
            up_d  = 1'b1;
          end else if (up_q && cnt_q < period) begin
            cnt_d = cnt_q + ONE;
          end else if (cnt_q == '0) begin
            cnt_d = ONE;
            up_d  = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) begin
              ovf_set = 1'b1;
              up_d    = 1'b1;
            end else begin
              up_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 2,
  parameter int SEL_W = 2,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq
);
  localparam int PAD_W = W - B_SEL - SEL_W;

  logic             flag_q, ie_q, clr_pulse, adv, ovf_set, tick_sel;
  tmr_mode_e        mode_q;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic [W-1:0]     cnt_q, period_q;
  logic             wr_ctrl, wr_period;

  assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  assign wr_period = reg_wr && reg_addr == A_PERIOD;
  assign tick_sel  = src_tick[sel_q];

  tmr16_ctrl #(.W(W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .ovf_set(ovf_set), .flag_q(flag_q), .ie_q(ie_q), .mode_q(mode_q),
    .div_q(div_q), .sel_q(sel_q), .clr_pulse(clr_pulse)
  );

  tmr16_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel), .run(mode_q != MODE_HALT),
    .clr(clr_pulse), .div(div_q), .adv(adv)
  );

  tmr16_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .adv(adv), .mode(mode_q),
    .period(period_q), .cnt_q(cnt_q), .ovf_set(ovf_set)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         period_q <= '0;
    else if (wr_period) period_q <= reg_wdata;
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = {{PAD_W{1'b0}}, sel_q, div_q, mode_q, 2'b00, ie_q, flag_q};
      A_COUNT:  reg_rdata = cnt_q;
      A_PERIOD: reg_rdata = period_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/tmr16_core_chk.sv
module tmr16_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic [1:0]   mode,
  input logic         flag,
  input logic         ie,
  input logic         irq,
  input logic         clr,
  input logic         adv,
  input logic         ovf
);
  // R1
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !clr) |=> $stable(cnt));

  // R2
  up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && cnt <= period && !(reg_wr && reg_addr == 2'd2))
    |=> cnt <= $past(period));

  // R3
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && adv && (&cnt)) |=> (cnt == '0 && flag));

  // R4
  updn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && period == '0 && adv) |=> cnt == '0);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  // R7
  hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));
endmodule

bind tmr16_core tmr16_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cnt(cnt_q), .period(period_q), .mode(mode_q), .flag(flag_q), .ie(ie_q),
  .irq(irq), .clr(clr_pulse), .adv(adv), .ovf(ovf_set)
);

// File: tb/tmr16_core_tb_top.sv
module tmr16_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = 4'b0001;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R9";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_core dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt, m_per, m_pre, m_mode, m_div, m_sel;
  bit m_up, m_flag, m_ie, m_hw, m_clr;

  task automatic model_step();
    case (m_mode)
      1: if (m_cnt >= m_per) begin m_cnt = 0; m_hw = 1; end else m_cnt++;
      2: if (m_cnt == 65535) begin m_cnt = 0; m_hw = 1; end else m_cnt++;
      3: begin
        if (m_per == 0) begin m_cnt = 0; m_up = 1; end
        else if (m_up && m_cnt < m_per) m_cnt++;
        else if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
        else begin
          m_cnt--;
          m_up = (m_cnt == 0);
          if (m_cnt == 0) m_hw = 1;
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_pre = 0; m_mode = 0; m_div = 0; m_sel = 0;
      m_up = 1; m_flag = 0; m_ie = 0;
    end else begin
      m_hw  = 0;
      m_clr = reg_wr && reg_addr == 2'd0 && reg_wdata[2];
      if (m_clr) begin
        m_cnt = 0; m_pre = 0; m_up = 1;
      end else if (m_mode != 0 && src_tick[m_sel]) begin
        if (m_pre + 1 >= (1 << m_div)) begin m_pre = 0; model_step(); end
        else m_pre++;
      end
      if (reg_wr && reg_addr == 2'd0) begin
        m_flag = m_hw | reg_wdata[0];
        m_ie   = reg_wdata[1];
        m_mode = int'(reg_wdata[5:4]);
        m_div  = int'(reg_wdata[7:6]);
        m_sel  = int'(reg_wdata[9:8]);
      end else begin
        m_flag = m_flag | m_hw;
      end
      if (reg_wr && reg_addr == 2'd2) m_per = int'(reg_wdata);
    end
  end

  function automatic int exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return (m_sel << 8) | (m_div << 6) | (m_mode << 4) | (int'(m_ie) << 1) | int'(m_flag);
      2'd1: return m_cnt;
      2'd2: return m_per;
      default: return 0;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(int'(reg_rdata) == exp_rdata(reg_addr), cur_req, int'(reg_rdata), exp_rdata(reg_addr));
    chk(irq == (m_flag & m_ie), {cur_req, "/R8 irq"}, int'(irq), int'(m_flag & m_ie));
    src_tick[0] = 1'b1;
    src_tick[1] = ~src_tick[1];
    src_tick[2] = 1'($urandom);
    src_tick[3] = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  function automatic logic [15:0] ctl(input int sel, input int dv, input int md,
                                      input bit clr, input bit ie, input bit fl);
    return 16'((sel << 8) | (dv << 6) | (md << 4) | (int'(clr) << 2) | (int'(ie) << 1) | int'(fl));
  endfunction

  initial begin : main
    int v, v0;
    int seq[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset values
    rd(2'd0, v); chk(v == 0, "R9 ctrl", v, 0);
    rd(2'd2, v); chk(v == 0, "R9 period", v, 0);
    rd(2'd1, v); chk(v == 0, "R9 count", v, 0);
    chk(irq == 0, "R9 irq", int'(irq), 0);
    step();

    // R2 up mode, period 5
    cur_req = "R2";
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(0, 0, 1, 1, 1, 0));
    repeat (6) step();
    rd(2'd1, v); chk(v == 0, "R2 wrap to 0", v, 0);
    rd(2'd0, v); chk(v[0] == 1'b1, "R2 flag", v & 1, 1);
    chk(irq == 1'b1, "R8 irq on", int'(irq), 1);
    step();
    // R7 software clear of flag
    cur_req = "R7";
    wr(2'd0, ctl(0, 0, 1, 0, 1, 0));
    rd(2'd0, v); chk(v[0] == 1'b0, "R7 flag cleared", v & 1, 0);
    chk(irq == 1'b0, "R8 irq off", int'(irq), 0);
    step();

    // R1 halt holds
    cur_req = "R1";
    wr(2'd0, ctl(0, 0, 0, 0, 0, 0));
    rd(2'd1, v0);
    repeat (10) step();
    rd(2'd1, v); chk(v == v0, "R1 halt hold", v, v0);

    // R10 register map
    cur_req = "R10";
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk(v == v0, "R10 count write ignored", v, v0);
    rd(2'd3, v); chk(v == 0, "R10 addr3 zero", v, 0);
    wr(2'd2, 16'hABCD);
    rd(2'd2, v); chk(v == 16'hABCD, "R10 period readback", v, 16'hABCD);
    wr(2'd0, 16'hFFFB);
    rd(2'd0, v); chk(v == 16'h03F3, "R10 ctrl readback", v, 16'h03F3);
    step();

    // R6 clear
    cur_req = "R6";
    wr(2'd0, ctl(0, 0, 1, 1, 0, 0));
    rd(2'd1, v); chk(v == 0, "R6 count cleared", v, 0);
    rd(2'd0, v); chk(v[2] == 1'b0, "R6 clear reads 0", (v >> 2) & 1, 0);
    step();
    rd(2'd1, v); chk(v == 1, "R6 resumes upward", v, 1);

    // R4 up/down, period 3
    cur_req = "R4";
    wr(2'd2, 16'd3);
    wr(2'd0, ctl(0, 0, 3, 1, 0, 0));
    seq = {};
    for (int i = 0; i < 12; i++) begin
      step();
      rd(2'd1, v); seq.push_back(v);
    end
    foreach (seq[i]) begin
      int e;
      e = (i % 6 < 3) ? (i % 6) + 1 : 5 - (i % 6);
      chk(seq[i] == e, "R4 triangle", seq[i], e);
    end
    rd(2'd0, v); chk(v[0] == 1'b1, "R4 flag on 1->0", v & 1, 1);
    step();
    wr(2'd2, 16'd0);
    wr(2'd0, ctl(0, 0, 3, 1, 0, 0));
    repeat (5) step();
    rd(2'd1, v); chk(v == 0, "R4 period 0 stays", v, 0);

    // R5 divider and source select
    cur_req = "R5";
    wr(2'd2, 16'd100);
    wr(2'd0, ctl(0, 3, 1, 1, 0, 0));
    repeat (16) step();
    rd(2'd1, v); chk(v == 2, "R5 divide by 8", v, 2);
    wr(2'd0, ctl(3, 0, 1, 0, 0, 0));
    rd(2'd1, v0);
    repeat (10) step();
    rd(2'd1, v); chk(v == v0, "R5 idle source", v, v0);
    wr(2'd0, ctl(1, 1, 1, 1, 0, 0));
    repeat (40) step();

    // R3 continuous full wrap
    cur_req = "R3";
    wr(2'd0, ctl(0, 0, 2, 1, 0, 0));
    repeat (65535) step();
    rd(2'd1, v); chk(v == 16'hFFFF, "R3 top", v, 16'hFFFF);
    step();
    rd(2'd1, v); chk(v == 0, "R3 wrap", v, 0);
    rd(2'd0, v); chk(v[0] == 1'b1, "R3 flag", v & 1, 1);
    step();

    // randomised mix, compared to the model each clock (R7 races included)
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r == 0) wr(2'd2, 16'($urandom_range(0, 12)));
      else if (r == 1) wr(2'd0, 16'($urandom) & 16'h03F7 | (($urandom_range(0, 3) == 0) ? 16'h0004 : 16'h0));
      else begin
        reg_addr = 2'($urandom);
        step();
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule